// File: doc/BRIEF.md
# Slow Oscillator Liveness Checker

This block decides whether the slow real-time oscillator, nominally 32.768 kHz, is actually running. A free-running counter elsewhere in the chip is advanced by that oscillator. When asked, the checker forces that counter to count continuously, records its value, waits a fixed window, and records it again. It then releases the forced-count request and reports the verdict.

Identical samples mean that the oscillator did not tick during the window. This is what happens when the backup supply is missing or flat. Firmware or a power sequencer pulses the start input once and waits for the done strobe. It then reads the failed flag, which stays valid until the next check begins.

The window length is given in microseconds and turned into system-clock cycles from a clock-frequency parameter. Elaboration rejects any setting whose window is not longer than one oscillator period. An optional register stage on the counter input can be switched in by parameter.

Top module: `osc_live_check`

## Requirements
- R1: While reset is held and right after it, `cnt_always_o`, `done_o` and `failed_o` are all 0.
- R2: A `start_i` seen while no check is running raises `cnt_always_o` in the next cycle, and clears `failed_o` in that same cycle.
- R3: `cnt_always_o` stays high for exactly SETTLE_CYC + WIN_CYC consecutive cycles, where WIN_CYC = CLK_HZ * WINDOW_US / 1,000,000.
- R4: The first counter sample is taken SETTLE_CYC cycles after the forced-count request rises, and the second is taken WIN_CYC cycles after the first. `failed_o` becomes 1 exactly when the two samples are equal.
- R5: Any difference between the two samples gives a pass (`failed_o` = 0), including a wrap of the counter from all-ones to zero.
- R6: `done_o` is high for exactly one cycle. That cycle is the first one in which `cnt_always_o` is low again after a check.
- R7: `failed_o` keeps its value from the done cycle until the next accepted start.
- R8: A `start_i` pulse that arrives while a check is running is ignored. It does not change the length of the check, it produces no extra done pulse, and it does not clear `failed_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to start a liveness check |
| count_i | input | CNT_W | Value of the oscillator-driven counter |
| cnt_always_o | output | 1 | Forces the counter to count continuously while high |
| done_o | output | 1 | One-cycle pulse when a verdict is ready |
| failed_o | output | 1 | 1 when the oscillator was found idle |

## Verification
A phase counter stuck or loaded with the wrong value shows up at the ports straight away. The forced-count pulse becomes longer or shorter than SETTLE_CYC + WIN_CYC cycles, and this is visible on the first check after the fault. A stale or badly captured first sample turns into a wrong verdict on `failed_o` in the done cycle. This is most exposed when the oscillator divisor equals the window length, because then only one tick falls inside the window. A state register that lets a second start through shows up during the running check, as a cleared `failed_o` or a done pulse at the wrong time.

// File: rtl/osc_chk_pkg.sv
package osc_chk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_WAIT = 2'd2
   } chk_state_e;

   function automatic longint cycles_for_us(input longint clk_hz, input longint us);
      return (clk_hz * us) / 64'd1000000;
   endfunction

   function automatic longint cycles_per_tick(input longint clk_hz, input longint osc_hz);
      return (clk_hz + osc_hz - 1) / osc_hz;
   endfunction

endpackage

// File: rtl/osc_chk_timer.sv
module osc_chk_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R3: the window only shrinks one step per cycle between loads
   a_r3_steady_countdown : assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/osc_chk_sampler.sv
module osc_chk_sampler #(
   parameter int CNT_W  = 32,
   parameter bit IN_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic             capture_i,
   output logic             match_o
);

   logic [CNT_W-1:0] cur_cnt;
   logic [CNT_W-1:0] ref_q;

   generate
      if (IN_REG) begin : g_in_reg
         logic [CNT_W-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage_q <= '0;
            else
               stage_q <= count_i;
         end
         assign cur_cnt = stage_q;
      end else begin : g_in_direct
         assign cur_cnt = count_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ref_q <= '0;
      else if (capture_i)
         ref_q <= cur_cnt;
   end

   assign match_o = (cur_cnt == ref_q);

endmodule

// File: rtl/osc_chk_fsm.sv
module osc_chk_fsm
   import osc_chk_pkg::*;
#(
   parameter int               TMR_W     = 8,
   parameter logic [TMR_W-1:0] SETTLE_LD = '0,
   parameter logic [TMR_W-1:0] WIN_LD    = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tmr_zero_i,
   input  logic             match_i,
   output logic             tmr_load_o,
   output logic [TMR_W-1:0] tmr_val_o,
   output logic             capture_o,
   output logic             en_o,
   output logic             done_o,
   output logic             failed_o
);

   chk_state_e state_q, state_d;
   logic       accept, finish;
   logic       en_q, done_q, fail_q;

   assign accept     = (state_q == ST_IDLE) && start_i;
   assign capture_o  = (state_q == ST_ARM) && tmr_zero_i;
   assign finish     = (state_q == ST_WAIT) && tmr_zero_i;
   assign tmr_load_o = accept || capture_o;
   assign tmr_val_o  = accept ? SETTLE_LD : WIN_LD;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i)    state_d = ST_ARM;
         ST_ARM:  if (tmr_zero_i) state_d = ST_WAIT;
         ST_WAIT: if (tmr_zero_i) state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         en_q    <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         if (accept)
            en_q <= 1'b1;
         else if (finish)
            en_q <= 1'b0;
         if (accept)
            fail_q <= 1'b0;
         else if (finish)
            fail_q <= match_i;
      end
   end

   assign en_o     = en_q;
   assign done_o   = done_q;
   assign failed_o = fail_q;

   // R2: an accepted start raises the request and clears the verdict
   a_r2_start_arms : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (en_q && !fail_q));

   // R6: done is a lone pulse that coincides with the request dropping
   a_r6_single_done : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r6_done_at_release : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!en_q && $past(en_q)));

   // R7: the verdict only moves at a done pulse or an accepted start
   a_r7_verdict_held : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fail_q) |-> (done_q || $past(accept)));

   // R8: the request can only rise out of the idle state
   a_r8_rise_from_idle : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> ($past(state_q) == ST_IDLE));

endmodule

// File: rtl/osc_live_check.sv
module osc_live_check
   import osc_chk_pkg::*;
#(
   parameter int CLK_HZ     = 200_000_000,
   parameter int OSC_HZ     = 32_768,
   parameter int WINDOW_US  = 50,
   parameter int SETTLE_CYC = 2,
   parameter int CNT_W      = 32,
   parameter bit IN_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             cnt_always_o,
   output logic             done_o,
   output logic             failed_o
);

   localparam longint WIN_L   = cycles_for_us(longint'(CLK_HZ), longint'(WINDOW_US));
   localparam longint TICK_L  = cycles_per_tick(longint'(CLK_HZ), longint'(OSC_HZ));
   localparam int     WIN_CYC = int'(WIN_L);
   localparam int     MAX_LD  = (WIN_CYC > SETTLE_CYC) ? WIN_CYC : SETTLE_CYC;
   localparam int     TMR_W   = $clog2(MAX_LD + 1);
   localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
   localparam logic [TMR_W-1:0] WIN_LD    = TMR_W'(WIN_CYC - 1);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (WIN_L <= TICK_L) begin : g_bad_window
         $error("window must be longer than one oscillator period");
      end
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic             tmr_load, tmr_zero;
   logic [TMR_W-1:0] tmr_val;
   logic             capture, match;

   osc_chk_timer #(.TMR_W(TMR_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   osc_chk_sampler #(.CNT_W(CNT_W), .IN_REG(IN_REG)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_i   (count_i),
      .capture_i (capture),
      .match_o   (match)
   );

   osc_chk_fsm #(
      .TMR_W     (TMR_W),
      .SETTLE_LD (SETTLE_LD),
      .WIN_LD    (WIN_LD)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .tmr_zero_i (tmr_zero),
      .match_i    (match),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .capture_o  (capture),
      .en_o       (cnt_always_o),
      .done_o     (done_o),
      .failed_o   (failed_o)
   );

endmodule

// File: tb/osc_live_check_tb.sv
`timescale 1ns/1ps
module osc_live_check_tb_top;

   localparam int CLK_HZ = 4_000_000;
   localparam int WIN    = CLK_HZ / 1_000_000 * 50;
   localparam int SETTLE = 2;
   localparam int CNT_W  = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] count = '0;
   logic             en, done, failed;

   int n_checks = 0;
   int n_errors = 0;

   logic        alive = 1'b0;
   int          div   = 100;
   logic [15:0] phase = '0;

   always #2.5 clk = ~clk;

   osc_live_check #(
      .CLK_HZ     (CLK_HZ),
      .SETTLE_CYC (SETTLE),
      .CNT_W      (CNT_W),
      .IN_REG     (1'b1)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .count_i      (count),
      .cnt_always_o (en),
      .done_o       (done),
      .failed_o     (failed)
   );

   // oscillator model: a tick every div cycles, counted only while forced
   always @(posedge clk) begin
      if (alive) begin
         if (int'(phase) >= div - 1) begin
            phase <= '0;
            if (en) count <= count + 1'b1;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   function automatic logic exp_fail(input logic is_alive, input int d);
      return !(is_alive && d <= WIN);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_check(input logic is_alive, input int d,
                            input logic [CNT_W-1:0] init, input int mid_at);
      int   n;
      logic en_ok;
      logic fexp;
      logic prev_fail;
      alive = is_alive;
      div   = d;
      count = init;
      @(negedge clk);
      prev_fail = failed;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 enable after start", en, 1);
      check("R2 verdict cleared", failed, 0);
      n = 0;
      en_ok = 1'b1;
      while (!done && n < WIN + SETTLE + 20) begin
         if (!en) en_ok = 1'b0;
         if (mid_at > 0 && n == mid_at) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
            if (failed !== 1'b0) en_ok = 1'b0;
         end else begin
            @(negedge clk);
            n++;
         end
      end
      if (mid_at > 0) begin
         check("R8 mid start length", n, SETTLE + WIN);
         check("R8 mid start kept request", en_ok, 1);
      end else begin
         check("R3 request length", n, SETTLE + WIN);
         check("R3 request steady", en_ok, 1);
      end
      fexp = exp_fail(is_alive, d);
      check("R6 request low at done", en, 0);
      if (is_alive && init == '1)
         check("R5 wrap counts as pass", failed, fexp);
      else
         check("R4 verdict", failed, fexp);
      @(negedge clk);
      check("R6 done one cycle", done, 0);
      for (int i = 0; i < 5; i++) @(negedge clk);
      check("R7 verdict held", failed, fexp);
      check("R8 no extra done", done, 0);
      if (prev_fail === 1'bx) check("R7 prior verdict known", 0, 1);
   endtask

   initial begin
      #2_000_000;
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset request", en, 0);
      check("R1 reset done", done, 0);
      check("R1 reset failed", failed, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset request", en, 0);
      check("R1 after reset failed", failed, 0);

      // directed corners
      run_check(1'b0, 100, 32'h0000_1234, 0);   // dead oscillator
      run_check(1'b1, 100, 32'h0000_1234, 0);   // alive, clears previous fail
      run_check(1'b1, 10,  32'hFFFF_FFFF, 0);   // wrap
      run_check(1'b1, WIN, 32'h0000_0042, 0);   // slowest allowed: one tick
      run_check(1'b0, 50,  32'h0000_0007, 40);  // start during a failing check
      run_check(1'b1, 30,  32'h0000_0100, 150); // start during a passing check

      // random mix
      for (int k = 0; k < 16; k++) begin
         logic a;
         int   d;
         int   m;
         a = ($urandom % 3) != 0;
         d = 20 + int'($urandom % (WIN - 19));
         m = (($urandom % 4) == 0) ? 1 + int'($urandom % (WIN - 1)) : 0;
         run_check(a, d, $urandom, m);
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule